// File: doc/BRIEF.md
# Byte-Masked Fuse Page Controller

This block fronts an array of one-time-programmable style pages, each 128 bits wide, through a small register bank on a simple request/response bus. Software loads a staging buffer of four 32-bit words and sets a 16-bit lane mask. It then writes one control register whose low bits name a page and whose command bits start a program, a fetch, or both. Programming copies the enabled bytes of the staging buffer into the page. Fetching copies the enabled bytes of the page back into the staging buffer. Every control write raises a completion flag that software clears by writing one.

Each request is answered exactly one cycle later. A request with an illegal transfer size or an unmapped offset is answered with an error pulse and changes nothing. Each register also insists on its own transfer width.

Top module: `otp_page_ctrl`

## Requirements
- R1: After reset, control reads 0x0000, lane mask 0xFFFF, status 0x0000, timing 0x00001485 and the four staging words 0.
- R2: The size code on `req_size` is 0 for 8 bits, 1 for 16 bits, 2 for 32 bits and 3 for 64 bits. Codes 0 and 3 are answered with an error at any offset, mapped or not.
- R3: Offsets other than 0x00 (control), 0x04 (lane mask), 0x08 (status), 0x0C (timing) and 0x80/0x84/0x88/0x8C (staging words 0 to 3) are answered with an error.
- R4: Control, lane mask and status accept only 16-bit transfers. Timing and the staging words accept only 32-bit transfers. A mismatched or rejected access changes no state and returns read data 0.
- R5: A control write stores only bits under mask 0x39FF. The page number is bits [8:0], the program command is bit 11 and the fetch command is bit 12.
- R6: Programming copies staging byte i into page byte i wherever lane-mask bit i is 1. Byte 0 is bits [7:0] of staging word 0, and byte 15 is bits [31:24] of staging word 3.
- R7: Fetching copies page byte i into staging byte i wherever lane-mask bit i is 1. All other staging bytes keep their value.
- R8: When both commands are set, the program is applied before the fetch, so the fetch sees the freshly programmed bytes.
- R9: Every accepted control write sets status bit 0 (done).
- R10: A status write clears each status bit written as 1 and leaves bits written as 0 unchanged.
- R11: All 16 lane-mask bits and all 32 timing bits are writable and read back as written.
- R12: `rsp_valid` follows `req_valid` by exactly one cycle. A page transfer is visible to a staging-word read issued on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset within the bank |
| req_size | input | 2 | Transfer size code (see R2) |
| req_wdata | input | 32 | Write data; 16-bit registers use bits [15:0] |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Access was rejected |
| rsp_rdata | output | 32 | Read data, zero-extended for 16-bit registers |

## Verification
A single control write can program a page and fetch it back in the same cycle. The order between the two is observable when the page already holds other contents. The bench loads the staging words with values different from a previously programmed page and issues one control write with both command bits set. It then reads the staging words: a program-first design returns the staging values unchanged, and a fetch-first design returns the old page. A second fetch, made after new staging values are loaded, then confirms that the page itself now holds the programmed values.

// File: rtl/otp_ctrl_pkg.sv
package otp_ctrl_pkg;
  localparam int PAGE_BYTES = 16;
  localparam int PAGE_BITS  = PAGE_BYTES * 8;
  localparam int WORDS      = PAGE_BYTES / 4;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_DBL  = 2'd3;

  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_LANE = 8'h04;
  localparam logic [7:0] OFF_STAT = 8'h08;
  localparam logic [7:0] OFF_TIME = 8'h0C;
  localparam logic [7:0] OFF_BUF0 = 8'h80;
  localparam logic [7:0] OFF_BUF3 = 8'h8C;

  localparam logic [15:0] CTRL_KEEP  = 16'h39FF;
  localparam int          BIT_PROG   = 11;
  localparam int          BIT_FETCH  = 12;
  localparam int          BIT_DONE   = 0;
  localparam logic [15:0] LANE_RESET = 16'hFFFF;
  localparam logic [31:0] TIME_RESET = 32'h0000_1485;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_LANE, SEL_STAT, SEL_TIME, SEL_BUF
  } reg_sel_e;

  // Take new bytes where the lane bit is set, old bytes elsewhere.
  function automatic logic [PAGE_BITS-1:0] lane_merge(
      input logic [PAGE_BITS-1:0]  old_v,
      input logic [PAGE_BITS-1:0]  new_v,
      input logic [PAGE_BYTES-1:0] lanes);
    logic [PAGE_BITS-1:0] r;
    for (int b = 0; b < PAGE_BYTES; b++)
      r[b*8 +: 8] = lanes[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
    return r;
  endfunction

  // Widen a lane mask to a bit mask.
  function automatic logic [PAGE_BITS-1:0] lane_bits(input logic [PAGE_BYTES-1:0] lanes);
    logic [PAGE_BITS-1:0] r;
    for (int b = 0; b < PAGE_BYTES; b++)
      r[b*8 +: 8] = {8{lanes[b]}};
    return r;
  endfunction

  function automatic logic size_legal(input logic [1:0] sz);
    return (sz == SZ_HALF) || (sz == SZ_WORD);
  endfunction
endpackage

// File: rtl/otp_reg_decode.sv
module otp_reg_decode
  import otp_ctrl_pkg::*;
(
  input  logic       req_valid,
  input  logic [7:0] req_addr,
  input  logic [1:0] req_size,
  output reg_sel_e   sel,
  output logic [1:0] word_idx,
  output logic       acc_ok,
  output logic       acc_err
);
  logic [1:0] need_size;
  logic       size_ok;

  always_comb begin
    sel       = SEL_NONE;
    need_size = SZ_HALF;
    word_idx  = req_addr[3:2];
    unique case (req_addr)
      OFF_CTRL: sel = SEL_CTRL;
      OFF_LANE: sel = SEL_LANE;
      OFF_STAT: sel = SEL_STAT;
      OFF_TIME: begin sel = SEL_TIME; need_size = SZ_WORD; end
      default: begin
        if (req_addr >= OFF_BUF0 && req_addr <= OFF_BUF3 && req_addr[1:0] == 2'b00) begin
          sel       = SEL_BUF;
          need_size = SZ_WORD;
        end
      end
    endcase
  end

  // Size legality outranks the offset lookup; both lead to the same error pulse.
  assign size_ok = size_legal(req_size);
  assign acc_err = req_valid && (!size_ok || sel == SEL_NONE || req_size != need_size);
  assign acc_ok  = req_valid && !acc_err;
endmodule

// File: rtl/otp_page_store.sv
module otp_page_store #(
  parameter int PAGES  = 512,
  parameter int BYTES  = 16,
  localparam int AW    = $clog2(PAGES),
  localparam int BITS  = BYTES * 8
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_page,
  input  logic [BYTES-1:0] wr_lanes,
  input  logic [BITS-1:0]  wr_bytes,
  input  logic [AW-1:0]    rd_page,
  output logic [BITS-1:0]  rd_bytes
);
  logic [BITS-1:0] cells [PAGES];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < BYTES; b++)
        if (wr_lanes[b]) cells[wr_page][b*8 +: 8] <= wr_bytes[b*8 +: 8];
    end
  end

  assign rd_bytes = cells[rd_page];
endmodule

// File: rtl/otp_stage_buf.sv
module otp_stage_buf
  import otp_ctrl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [1:0]            bus_idx,
  input  logic [31:0]           bus_word,
  input  logic                  load_en,
  input  logic [PAGE_BITS-1:0]  load_bytes,
  input  logic [PAGE_BYTES-1:0] load_lanes,
  output logic [PAGE_BITS-1:0]  bytes_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bytes_q <= '0;
    end else if (load_en) begin
      bytes_q <= lane_merge(bytes_q, load_bytes, load_lanes);
    end else if (bus_we) begin
      bytes_q[bus_idx*32 +: 32] <= bus_word;
    end
  end

  // Bytes outside the lane mask survive a fetch.
  assert_fetch_keeps_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> ((bytes_q & ~lane_bits($past(load_lanes))) ==
                 ($past(bytes_q) & ~lane_bits($past(load_lanes)))));
endmodule

// File: rtl/otp_page_ctrl.sv
module otp_page_ctrl
  import otp_ctrl_pkg::*;
#(
  parameter int PAGES = 512,
  localparam int AW   = $clog2(PAGES)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic        rsp_err,
  output logic [31:0] rsp_rdata
);
  reg_sel_e        sel;
  logic [1:0]      word_idx;
  logic            acc_ok, acc_err;

  logic [15:0]     ctrl_q, lane_q, status_q;
  logic [31:0]     timing_q;
  logic [PAGE_BITS-1:0] stage_q, page_now, page_after;

  // Named events for the assertions.
  logic ctrl_wr_ev, stat_wr_ev, buf_wr_ev, cmd_prog, cmd_fetch;
  logic [AW-1:0] page_sel;
  logic [31:0]   rd_mux;

  otp_reg_decode u_dec (
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .sel       (sel),
    .word_idx  (word_idx),
    .acc_ok    (acc_ok),
    .acc_err   (acc_err)
  );

  assign ctrl_wr_ev = acc_ok && req_write && sel == SEL_CTRL;
  assign stat_wr_ev = acc_ok && req_write && sel == SEL_STAT;
  assign buf_wr_ev  = acc_ok && req_write && sel == SEL_BUF;
  assign cmd_prog   = ctrl_wr_ev && req_wdata[BIT_PROG];
  assign cmd_fetch  = ctrl_wr_ev && req_wdata[BIT_FETCH];
  assign page_sel   = req_wdata[AW-1:0];

  otp_page_store #(.PAGES(PAGES), .BYTES(PAGE_BYTES)) u_store (
    .clk      (clk),
    .wr_en    (cmd_prog),
    .wr_page  (page_sel),
    .wr_lanes (lane_q),
    .wr_bytes (stage_q),
    .rd_page  (page_sel),
    .rd_bytes (page_now)
  );

  // Program first: the fetch sees the page as it will be after programming.
  assign page_after = cmd_prog ? lane_merge(page_now, stage_q, lane_q) : page_now;

  otp_stage_buf u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (buf_wr_ev),
    .bus_idx    (word_idx),
    .bus_word   (req_wdata),
    .load_en    (cmd_fetch),
    .load_bytes (page_after),
    .load_lanes (lane_q),
    .bytes_q    (stage_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      lane_q   <= LANE_RESET;
      status_q <= '0;
      timing_q <= TIME_RESET;
    end else if (acc_ok && req_write) begin
      unique case (sel)
        SEL_CTRL: begin
          ctrl_q             <= req_wdata[15:0] & CTRL_KEEP;
          status_q[BIT_DONE] <= 1'b1;
        end
        SEL_LANE: lane_q   <= req_wdata[15:0];
        SEL_STAT: status_q <= status_q & ~req_wdata[15:0];
        SEL_TIME: timing_q <= req_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_CTRL: rd_mux = {16'h0, ctrl_q};
      SEL_LANE: rd_mux = {16'h0, lane_q};
      SEL_STAT: rd_mux = {16'h0, status_q};
      SEL_TIME: rd_mux = timing_q;
      SEL_BUF:  rd_mux = stage_q[word_idx*32 +: 32];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= acc_err;
      rsp_rdata <= (acc_ok && !req_write) ? rd_mux : 32'h0;
    end
  end

  assert_rsp_follows_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_stray_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_bad_size_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_size == SZ_BYTE || req_size == SZ_DBL)) |=> (rsp_valid && rsp_err));
  assert_err_no_effect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> ($stable(ctrl_q) && $stable(lane_q) && $stable(status_q) &&
                 $stable(timing_q) && $stable(stage_q)));
  assert_done_raised_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_ev |=> status_q[BIT_DONE]);
  assert_w1c_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_ev |=> ((status_q & $past(req_wdata[15:0])) == 16'h0));
  assert_ctrl_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_ev |=> ((ctrl_q & ~CTRL_KEEP) == 16'h0));
endmodule

// File: tb/otp_page_ctrl_test.sv
module otp_page_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  otp_page_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  // Behavioural reference model.
  typedef byte unsigned page_t [16];
  page_t       pages [int];
  logic [15:0] m_ctrl = 16'h0, m_lane = 16'hFFFF, m_stat = 16'h0;
  logic [31:0] m_time = 32'h1485;
  logic [31:0] m_buf [4] = '{default: 32'h0};

  logic        exp_valid = 1'b0, exp_err = 1'b0;
  logic [31:0] exp_rd = '0;
  string       exp_tag = "R12";

  function automatic byte unsigned buf_byte(int i);
    return byte'(m_buf[i / 4] >> ((i % 4) * 8));
  endfunction

  task automatic set_buf_byte(int i, byte unsigned v);
    logic [31:0] w = m_buf[i / 4];
    int sh = (i % 4) * 8;
    w = (w & ~(32'hFF << sh)) | (32'(v) << sh);
    m_buf[i / 4] = w;
  endtask

  task automatic model(input logic w, input logic [7:0] a, input logic [1:0] sz,
                       input logic [31:0] d, output logic err, output logic [31:0] rd);
    int pg;
    rd = 0;
    err = 0;
    if (sz != 2'd1 && sz != 2'd2) err = 1;
    else if (a == 8'h00 || a == 8'h04 || a == 8'h08) err = (sz != 2'd1);
    else if (a == 8'h0C || a == 8'h80 || a == 8'h84 || a == 8'h88 || a == 8'h8C) err = (sz != 2'd2);
    else err = 1;
    if (err) return;
    if (w) begin
      case (a)
        8'h00: begin
          m_ctrl = d[15:0] & 16'h39FF;
          pg = int'(d[8:0]);
          if (!pages.exists(pg)) pages[pg] = '{default: 8'h00};
          if (d[11]) for (int i = 0; i < 16; i++) if (m_lane[i]) pages[pg][i] = buf_byte(i);
          if (d[12]) for (int i = 0; i < 16; i++) if (m_lane[i]) set_buf_byte(i, pages[pg][i]);
          m_stat = m_stat | 16'h1;
        end
        8'h04: m_lane = d[15:0];
        8'h08: m_stat = m_stat & ~d[15:0];
        8'h0C: m_time = d;
        default: m_buf[(a - 8'h80) / 4] = d;
      endcase
    end else begin
      case (a)
        8'h00: rd = {16'h0, m_ctrl};
        8'h04: rd = {16'h0, m_lane};
        8'h08: rd = {16'h0, m_stat};
        8'h0C: rd = m_time;
        default: rd = m_buf[(a - 8'h80) / 4];
      endcase
    end
  endtask

  task automatic compare();
    checks++;
    if (rsp_valid !== exp_valid) begin
      failures++;
      $display("FAIL R12 rsp_valid actual=%0b expected=%0b", rsp_valid, exp_valid);
    end
    if (exp_valid) begin
      checks++;
      if (rsp_err !== exp_err || rsp_rdata !== exp_rd) begin
        failures++;
        $display("FAIL %s err/rdata actual=%0b/%08h expected=%0b/%08h",
                 exp_tag, rsp_err, rsp_rdata, exp_err, exp_rd);
      end
    end
  endtask

  task automatic acc(input logic w, input logic [7:0] a, input logic [1:0] sz,
                     input logic [31:0] d, input string tag);
    logic e;
    logic [31:0] r;
    @(negedge clk);
    compare();
    req_valid = 1; req_write = w; req_addr = a; req_size = sz; req_wdata = d;
    model(w, a, sz, d, e, r);
    exp_valid = 1; exp_err = e; exp_rd = r; exp_tag = tag;
  endtask

  task automatic idle();
    @(negedge clk);
    compare();
    req_valid = 0; req_write = 0;
    exp_valid = 0; exp_tag = "R12";
  endtask

  task automatic wr16(input logic [7:0] a, input logic [15:0] d, input string t);
    acc(1, a, 2'd1, {16'h0, d}, t);
  endtask
  task automatic wr32(input logic [7:0] a, input logic [31:0] d, input string t);
    acc(1, a, 2'd2, d, t);
  endtask
  task automatic rd16(input logic [7:0] a, input string t);
    acc(0, a, 2'd1, 32'h0, t);
  endtask
  task automatic rd32(input logic [7:0] a, input string t);
    acc(0, a, 2'd2, 32'h0, t);
  endtask
  task automatic rd_buf(input string t);
    for (int k = 0; k < 4; k++) rd32(8'h80 + 8'(k * 4), t);
  endtask
  task automatic ld_buf(input logic [31:0] a0, input logic [31:0] a1,
                        input logic [31:0] a2, input logic [31:0] a3);
    wr32(8'h80, a0, "R12"); wr32(8'h84, a1, "R12");
    wr32(8'h88, a2, "R12"); wr32(8'h8C, a3, "R12");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset values
    rd16(8'h00, "R1"); rd16(8'h04, "R1"); rd16(8'h08, "R1"); rd32(8'h0C, "R1");
    rd_buf("R1");
    // R6 / R9: full program of page 5, done flag
    ld_buf(32'h03020100, 32'h07060504, 32'h0B0A0908, 32'h0F0E0D0C);
    wr16(8'h00, 16'h0805, "R6");
    rd16(8'h08, "R9");
    // R10: writing 0 leaves done set, writing 1 clears it
    wr16(8'h08, 16'h0000, "R10"); rd16(8'h08, "R10");
    wr16(8'h08, 16'h0001, "R10"); rd16(8'h08, "R10");
    // R7: masked fetch into a different staging pattern
    ld_buf(32'hAAAAAAAA, 32'hBBBBBBBB, 32'hCCCCCCCC, 32'hDDDDDDDD);
    wr16(8'h04, 16'h0F0F, "R11"); rd16(8'h04, "R11");
    wr16(8'h00, 16'h1005, "R7");
    rd_buf("R7");
    // R6: partial program, lanes 0 and 15 only, then full fetch
    wr16(8'h04, 16'h8001, "R6");
    ld_buf(32'h111111EE, 32'h22222222, 32'h33333333, 32'hFF444444);
    wr16(8'h00, 16'h0805, "R6");
    wr16(8'h04, 16'hFFFF, "R6");
    wr16(8'h00, 16'h1005, "R6");
    rd_buf("R6");
    // R8: program and fetch together; then refetch after a reload
    ld_buf(32'h5A5A0001, 32'h5A5A0002, 32'h5A5A0003, 32'h5A5A0004);
    wr16(8'h00, 16'h1805, "R8");
    rd_buf("R8");
    ld_buf(32'h0, 32'h0, 32'h0, 32'h0);
    wr16(8'h00, 16'h1005, "R8");
    rd_buf("R8");
    // R5: stored bits masked, top page
    wr16(8'h00, 16'hFFFF, "R5"); rd16(8'h00, "R5"); rd_buf("R5");
    // R12: back-to-back fetch then read, no idle between
    ld_buf(32'h12345678, 32'h9ABCDEF0, 32'h0F1E2D3C, 32'h4B5A6978);
    wr16(8'h00, 16'h0803, "R12");
    ld_buf(32'h0, 32'h1, 32'h2, 32'h3);
    wr16(8'h00, 16'h1003, "R12");
    rd32(8'h84, "R12");
    idle(); idle();
    // R2: illegal size codes, mapped and unmapped
    acc(1, 8'h00, 2'd0, 32'h0000_1805, "R2");
    acc(0, 8'h80, 2'd3, 32'h0, "R2");
    acc(1, 8'h40, 2'd0, 32'h0, "R2");
    // R3: unmapped offsets with legal sizes
    acc(0, 8'h10, 2'd2, 32'h0, "R3");
    acc(1, 8'h90, 2'd2, 32'h0, "R3");
    acc(0, 8'h06, 2'd1, 32'h0, "R3");
    // R4: width mismatches have no effect
    acc(1, 8'h00, 2'd2, 32'h0000_0807, "R4");
    acc(1, 8'h04, 2'd2, 32'h0, "R4");
    acc(1, 8'h0C, 2'd1, 32'h0, "R4");
    acc(1, 8'h80, 2'd1, 32'hDEAD, "R4");
    acc(0, 8'h08, 2'd2, 32'h0, "R4");
    rd16(8'h00, "R4"); rd16(8'h04, "R4"); rd16(8'h08, "R4");
    rd32(8'h0C, "R4"); rd32(8'h80, "R4");
    // R11: full-width lane mask and timing
    wr16(8'h04, 16'hA5C3, "R11"); rd16(8'h04, "R11");
    wr32(8'h0C, 32'hFEDC_BA98, "R11"); rd32(8'h0C, "R11");
    idle(); idle();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule